// File: doc/BRIEF.md
# Complement and Compare-Skip Executor

This block is one execution slice of an 8-bit accumulator machine. It decodes two 16-bit instructions and runs each over a four-phase instruction cycle. The first instruction inverts every bit of a register-file byte. The result goes either to the working register or back to the byte's own location, and the negative and zero flags are updated from it. The second instruction compares a register-file byte with the working register. When the two are equal, it asks the fetch stage to squash the instruction word or words that follow.

Operands are addressed with an 8-bit field. That field is combined either with a 4-bit bank register or with a fixed split mapping, which gives a 12-bit register-file address. The block drives a combinational read port and a single-cycle write strobe. It emits one skip pulse for each instruction word it discards. It also neutralises the squashed words itself, so they change nothing even if the fetch stage still presents them.

Top module: `ics_exec`

## Requirements
- R1: After reset `phase_o` is 0 and advances by one every clock, wrapping from 3 to 0. The instruction on `instr_i` is captured at the end of phase 0, and the operand is read during phase 1.
- R2: Inversion is selected when `instr_i[15:10]` = 6'b000111. With the destination bit `instr_i[9]` = 0, the working register takes the bitwise inverse of the operand at the end of phase 3, and no register-file write occurs.
- R3: With `instr_i[9]` = 1, inversion raises `rf_we_o` only in phase 3. In that phase `rf_wdata_o` is the inverse of the byte read, the write goes to the operand's address, and the working register is unchanged.
- R4: Inversion sets `neg_o` to bit 7 of its result and sets `zero_o` when the result is 8'h00. No other instruction alters either flag.
- R5: With `instr_i[8]` = 1 the address is {`bsr_i`, `instr_i[7:0]`}. With `instr_i[8]` = 0 it is {4'h0, f} for f below 8'h80 and {4'hF, f} otherwise.
- R6: Compare-skip is selected when `instr_i[15:9]` = 7'b0110001, with `instr_i[8]` as the bank bit. It never writes the register file or the working register and never changes the flags. When the operand differs from the working register, no skip is raised.
- R7: On an equal compare with `next_dw_i` = 0 in phase 3, `skip_o` pulses once in phase 3 of the compare. The next instruction cycle is then executed as a no-op.
- R8: On an equal compare with `next_dw_i` = 1, a second `skip_o` pulse follows in phase 3 of the next cycle. The two following cycles are executed as no-ops, and the cycle after them runs normally.
- R9: A compare-skip that is itself squashed raises no skip and squashes nothing.
- R10: Any other opcode (for example 16'hFFFF, 16'h1A13 or 16'h6013) leaves the working register, the flags and the register file untouched and raises no skip.
- R11: Reset clears the working register and both flags, drops any pending squash and returns the phase to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Fetched instruction word, sampled at end of phase 0 |
| next_dw_i | input | 1 | Following instruction occupies two words |
| bsr_i | input | BANK_W | Bank-select value for banked addressing |
| rf_rdata_i | input | DATA_W | Register-file read data for `rf_addr_o` |
| rf_addr_o | output | BANK_W+8 | Effective register-file address |
| rf_we_o | output | 1 | Register-file write strobe (phase 3 only) |
| rf_wdata_o | output | DATA_W | Register-file write data |
| wreg_o | output | DATA_W | Working register |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| skip_o | output | 1 | One pulse per squashed instruction word |
| phase_o | output | 2 | Current phase within the instruction cycle |

## Verification
The assertions take for granted several things about the inputs. `instr_i` is valid at the end of phase 0. `bsr_i` stays stable from phase 1 through phase 3, so the write address matches the read address. `rf_rdata_i` reflects `rf_addr_o` combinationally, and the register file does not change under the block between phase 1 and phase 3 except through `rf_we_o`. The bench keeps to this by driving the instruction word, the bank value and the two-word flag on the falling edge in phase 0 and holding them for the whole cycle. Its register-file model is a combinational read with a write on the rising edge.

// File: rtl/ics_pkg.sv
package ics_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned FADDR_W = 8;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_INV     = 2'd1,
    OP_CMPSKIP = 2'd2
  } op_e;

  localparam logic [5:0] OPC_INV     = 6'b000111;
  localparam logic [6:0] OPC_CMPSKIP = 7'b0110001;

  typedef struct packed {
    op_e  op;
    logic to_file;
  } dec_t;
endpackage

// File: rtl/ics_phase_gen.sv
module ics_phase_gen
  import ics_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  output phase_e     phase_o,
  output logic [3:0] ph_oh_o
);
  phase_e ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_Q1;
    else         ph_q <= phase_e'(ph_q + 2'd1);
  end

  for (genvar i = 0; i < 4; i++) begin : g_oh
    assign ph_oh_o[i] = (ph_q == phase_e'(2'(i)));
  end

  assign phase_o = ph_q;

  AST_PH_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(ph_oh_o)); // R1
  AST_PH_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_Q4) |=> (ph_q == PH_Q1)); // R1
endmodule

// File: rtl/ics_decode.sv
module ics_decode
  import ics_pkg::*;
#(
  parameter  int unsigned BANK_W = 4,
  localparam int unsigned EA_W   = BANK_W + FADDR_W
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [BANK_W-1:0]  bsr_i,
  output dec_t               dec_o,
  output logic [EA_W-1:0]    ea_o
);
  logic [FADDR_W-1:0] faddr;
  logic               banked;

  assign faddr  = instr_i[FADDR_W-1:0];
  assign banked = instr_i[8];

  always_comb begin
    dec_o         = '0;
    dec_o.op      = OP_NONE;
    dec_o.to_file = 1'b0;
    if (instr_i[15:10] == OPC_INV) begin
      dec_o.op      = OP_INV;
      dec_o.to_file = instr_i[9];
    end else if (instr_i[15:9] == OPC_CMPSKIP) begin
      dec_o.op = OP_CMPSKIP;
    end
  end

  // unbanked: lower half of f -> bank 0, upper half -> top bank
  always_comb begin
    if (banked) ea_o = {bsr_i, faddr};
    else        ea_o = {{BANK_W{faddr[FADDR_W-1]}}, faddr};
  end
endmodule

// File: rtl/ics_alu.sv
module ics_alu #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] wreg_i,
  output logic [DATA_W-1:0] inv_o,
  output logic              neg_o,
  output logic              zero_o,
  output logic              eq_o
);
  logic [DATA_W-1:0] diff;

  assign inv_o  = ~opnd_i;
  assign neg_o  = inv_o[DATA_W-1];
  assign zero_o = (inv_o == '0);
  assign diff   = opnd_i - wreg_i;
  assign eq_o   = (diff == '0);
endmodule

// File: rtl/ics_skip_ctl.sv
module ics_skip_ctl #(
  parameter  int unsigned MAX_SQUASH = 2,
  localparam int unsigned CNT_W      = $clog2(MAX_SQUASH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ph_q1_i,
  input  logic ph_q4_i,
  input  logic cmp_eq_i,
  input  logic next_dw_i,
  output logic kill_o,
  output logic skip_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             kill_q;
  logic             hit;

  assign hit = cmp_eq_i & ~kill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      kill_q <= 1'b0;
    end else begin
      if (ph_q1_i) kill_q <= (cnt_q != '0);
      if (ph_q4_i) begin
        if (hit)                         cnt_q <= next_dw_i ? CNT_W'(MAX_SQUASH) : CNT_W'(1);
        else if (kill_q && cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  // one pulse per squashed word: on the compare, then on each killed cycle with words left
  assign skip_o = ph_q4_i & (hit | (kill_q & (cnt_q > CNT_W'(1))));
  assign kill_o = kill_q;

  AST_SKIP_Q4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> ph_q4_i); // R7
  AST_CNT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_SQUASH)); // R8
  AST_HIT_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q4_i && hit) |=> (cnt_q != '0)); // R7
  AST_KILLED_NO_SKIP_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q4_i && kill_o) |=> (cnt_q < CNT_W'(MAX_SQUASH))); // R9
endmodule

// File: rtl/ics_exec.sv
module ics_exec
  import ics_pkg::*;
#(
  parameter  int unsigned DATA_W = 8,
  parameter  int unsigned BANK_W = 4,
  localparam int unsigned EA_W   = BANK_W + FADDR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic                next_dw_i,
  input  logic [BANK_W-1:0]   bsr_i,
  input  logic [DATA_W-1:0]   rf_rdata_i,
  output logic [EA_W-1:0]     rf_addr_o,
  output logic                rf_we_o,
  output logic [DATA_W-1:0]   rf_wdata_o,
  output logic [DATA_W-1:0]   wreg_o,
  output logic                neg_o,
  output logic                zero_o,
  output logic                skip_o,
  output logic [1:0]          phase_o
);
  phase_e             phase;
  logic [3:0]         ph_oh;
  logic [INSTR_W-1:0] ir_q;
  dec_t               dec;
  logic [DATA_W-1:0]  opnd_q, res_q, wreg_q;
  logic [DATA_W-1:0]  inv;
  logic               inv_n, inv_z, eq;
  logic               res_n_q, res_z_q, eq_q;
  logic               n_q, z_q;
  logic               kill;
  logic               run_inv;

  ics_phase_gen u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase),
    .ph_oh_o (ph_oh)
  );

  ics_decode #(.BANK_W(BANK_W)) u_dec (
    .instr_i (ir_q),
    .bsr_i   (bsr_i),
    .dec_o   (dec),
    .ea_o    (rf_addr_o)
  );

  ics_alu #(.DATA_W(DATA_W)) u_alu (
    .opnd_i (opnd_q),
    .wreg_i (wreg_q),
    .inv_o  (inv),
    .neg_o  (inv_n),
    .zero_o (inv_z),
    .eq_o   (eq)
  );

  ics_skip_ctl #(.MAX_SQUASH(2)) u_skip (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ph_q1_i   (ph_oh[0]),
    .ph_q4_i   (ph_oh[3]),
    .cmp_eq_i  ((dec.op == OP_CMPSKIP) && eq_q),
    .next_dw_i (next_dw_i),
    .kill_o    (kill),
    .skip_o    (skip_o)
  );

  assign run_inv = ~kill & (dec.op == OP_INV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q    <= '0;
      opnd_q  <= '0;
      res_q   <= '0;
      res_n_q <= 1'b0;
      res_z_q <= 1'b0;
      eq_q    <= 1'b0;
      wreg_q  <= '0;
      n_q     <= 1'b0;
      z_q     <= 1'b0;
    end else begin
      if (ph_oh[0]) ir_q   <= instr_i;
      if (ph_oh[1]) opnd_q <= rf_rdata_i;
      if (ph_oh[2]) begin
        res_q   <= inv;
        res_n_q <= inv_n;
        res_z_q <= inv_z;
        eq_q    <= eq;
      end
      if (ph_oh[3] && run_inv) begin
        if (!dec.to_file) wreg_q <= res_q;
        n_q <= res_n_q;
        z_q <= res_z_q;
      end
    end
  end

  assign rf_we_o    = ph_oh[3] & run_inv & dec.to_file;
  assign rf_wdata_o = res_q;
  assign wreg_o     = wreg_q;
  assign neg_o      = n_q;
  assign zero_o     = z_q;
  assign phase_o    = phase;

  AST_WE_Q4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (phase == PH_Q4)); // R3
  AST_WDATA_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (rf_wdata_o == ~$past(rf_rdata_i, 2))); // R3
  AST_WREG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_Q4) |=> $stable(wreg_o)); // R2
  AST_CMP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_Q4 && dec.op == OP_CMPSKIP) |=> $stable({wreg_o, neg_o, zero_o})); // R6
  AST_KILL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_Q4 && kill) |=> $stable({wreg_o, neg_o, zero_o})); // R7
  AST_KILL_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill |-> !rf_we_o); // R8
endmodule

// File: tb/ics_exec_tb_top.sv
module ics_exec_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr_i = '0;
  logic        next_dw_i = 1'b0;
  logic [3:0]  bsr_i = '0;
  logic [7:0]  rf_rdata_i;
  logic [11:0] rf_addr_o;
  logic        rf_we_o;
  logic [7:0]  rf_wdata_o;
  logic [7:0]  wreg_o;
  logic        neg_o, zero_o, skip_o;
  logic [1:0]  phase_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  ics_exec dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .instr_i    (instr_i),
    .next_dw_i  (next_dw_i),
    .bsr_i      (bsr_i),
    .rf_rdata_i (rf_rdata_i),
    .rf_addr_o  (rf_addr_o),
    .rf_we_o    (rf_we_o),
    .rf_wdata_o (rf_wdata_o),
    .wreg_o     (wreg_o),
    .neg_o      (neg_o),
    .zero_o     (zero_o),
    .skip_o     (skip_o),
    .phase_o    (phase_o)
  );

  logic [7:0] mem [0:4095];
  assign rf_rdata_i = mem[rf_addr_o];
  always @(posedge clk_i) if (rf_we_o) mem[rf_addr_o] <= rf_wdata_o;

  typedef struct packed {
    logic [15:0] instr;
    logic [3:0]  bsr;
    logic        dw;
    logic [1:0]  skips;
    logic        we;
    logic [11:0] waddr;
    logic [7:0]  wdata;
    logic [7:0]  wreg;
    logic        n;
    logic        z;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{16'h1C13, 4'h0, 1'b0, 2'd0, 1'b0, 12'h000, 8'h00, 8'hEC, 1'b1, 1'b0, 4'd2},  // R2 invert 0x13 -> W
    '{16'h1E85, 4'h0, 1'b0, 2'd0, 1'b1, 12'hF85, 8'hFF, 8'hEC, 1'b1, 1'b0, 4'd3},  // R3 write back, upper access half
    '{16'h1F85, 4'h2, 1'b0, 2'd0, 1'b1, 12'h285, 8'h00, 8'hEC, 1'b0, 1'b1, 4'd5},  // R5 banked, R4 zero flag
    '{16'h1D40, 4'h3, 1'b0, 2'd0, 1'b0, 12'h000, 8'h00, 8'h80, 1'b1, 1'b0, 4'd4},  // R4 negative flag
    '{16'h6340, 4'h3, 1'b1, 2'd0, 1'b0, 12'h000, 8'h00, 8'h80, 1'b1, 1'b0, 4'd6},  // R6 unequal compare
    '{16'h6290, 4'h3, 1'b0, 2'd1, 1'b0, 12'h000, 8'h00, 8'h80, 1'b1, 1'b0, 4'd7},  // R7 equal, one word
    '{16'h1C13, 4'h0, 1'b0, 2'd0, 1'b0, 12'h000, 8'h00, 8'h80, 1'b1, 1'b0, 4'd7},  // R7 squashed
    '{16'h6290, 4'h0, 1'b1, 2'd1, 1'b0, 12'h000, 8'h00, 8'h80, 1'b1, 1'b0, 4'd8},  // R8 equal, two words
    '{16'h1E85, 4'h0, 1'b0, 2'd1, 1'b0, 12'h000, 8'h00, 8'h80, 1'b1, 1'b0, 4'd8},  // R8 first word squashed
    '{16'h1E85, 4'h0, 1'b0, 2'd0, 1'b0, 12'h000, 8'h00, 8'h80, 1'b1, 1'b0, 4'd8},  // R8 second word squashed
    '{16'h1E85, 4'h0, 1'b0, 2'd0, 1'b1, 12'hF85, 8'h00, 8'h80, 1'b0, 1'b1, 4'd8},  // R8 runs again
    '{16'hFFFF, 4'h0, 1'b0, 2'd0, 1'b0, 12'h000, 8'h00, 8'h80, 1'b0, 1'b1, 4'd10}, // R10
    '{16'h1A13, 4'h0, 1'b0, 2'd0, 1'b0, 12'h000, 8'h00, 8'h80, 1'b0, 1'b1, 4'd10}, // R10
    '{16'h6013, 4'h0, 1'b0, 2'd0, 1'b0, 12'h000, 8'h00, 8'h80, 1'b0, 1'b1, 4'd10}, // R10
    '{16'h6390, 4'hF, 1'b0, 2'd1, 1'b0, 12'h000, 8'h00, 8'h80, 1'b0, 1'b1, 4'd5},  // R5 bank 15 banked compare
    '{16'h6290, 4'h0, 1'b0, 2'd0, 1'b0, 12'h000, 8'h00, 8'h80, 1'b0, 1'b1, 4'd9},  // R9 squashed compare
    '{16'h1C13, 4'h0, 1'b0, 2'd0, 1'b0, 12'h000, 8'h00, 8'hEC, 1'b1, 1'b0, 4'd9}   // R9 not squashed
  };

  task automatic chk(input int act, input int exp, input int req, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL R%0d %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // entered on a falling edge in phase 0; leaves on the falling edge of the next phase 0
  task automatic do_row(input vec_t v);
    int         sk = 0;
    logic       we = 1'b0;
    logic [11:0] wa = '0;
    logic [7:0]  wd = '0;
    instr_i   = v.instr;
    bsr_i     = v.bsr;
    next_dw_i = v.dw;
    for (int k = 0; k < 4; k++) begin
      if (k != 0) @(negedge clk_i);
      if (skip_o) sk++;
      if (rf_we_o) begin
        we = 1'b1;
        wa = rf_addr_o;
        wd = rf_wdata_o;
      end
    end
    @(negedge clk_i);
    chk(sk, int'(v.skips), int'(v.req), "skip pulses");
    chk(int'(we), int'(v.we), int'(v.req), "write strobe");
    if (v.we) begin
      chk(int'(wa), int'(v.waddr), int'(v.req), "write address");
      chk(int'(wd), int'(v.wdata), int'(v.req), "write data");
    end
    chk(int'(wreg_o), int'(v.wreg), int'(v.req), "working reg");
    chk(int'(neg_o), int'(v.n), int'(v.req), "neg flag");
    chk(int'(zero_o), int'(v.z), int'(v.req), "zero flag");
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    vec_t sq;
    vec_t after;
    for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
    mem[12'h013] = 8'h13;
    mem[12'hF85] = 8'h00;
    mem[12'h285] = 8'hFF;
    mem[12'h340] = 8'h7F;
    mem[12'hF90] = 8'h80;
    mem[12'h2AA] = 8'hEC;

    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(int'(wreg_o), 0, 11, "reset wreg");
    chk(int'({neg_o, zero_o}), 0, 11, "reset flags");
    chk(int'(skip_o), 0, 11, "reset skip");
    chk(int'(rf_we_o), 0, 11, "reset write");
    rst_ni = 1'b1;

    // R1 phase sequence
    for (int k = 0; k < 8; k++) begin
      chk(int'(phase_o), k % 4, 1, "phase count");
      @(negedge clk_i);
    end

    for (int i = 0; i < NV; i++) do_row(VECS[i]);
    chk(int'(mem[12'h013]), 8'h13, 2, "file byte kept on W destination"); // R2

    // R11: a pending two-word squash is dropped by reset
    sq    = '{16'h63AA, 4'h2, 1'b1, 2'd1, 1'b0, 12'h000, 8'h00, 8'hEC, 1'b1, 1'b0, 4'd7};
    do_row(sq);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(int'(wreg_o), 0, 11, "mid reset wreg");
    chk(int'(phase_o), 0, 11, "mid reset phase");
    @(negedge clk_i);
    rst_ni = 1'b1;
    after = '{16'h1C13, 4'h0, 1'b0, 2'd0, 1'b0, 12'h000, 8'h00, 8'hEC, 1'b1, 1'b0, 4'd11};
    do_row(after);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule